// File: doc/BRIEF.md
# IN-Endpoint Interrupt Status Aggregator

This block keeps the interrupt status of four IN endpoints of a full-speed USB device controller. The protocol engine sends one-cycle event pulses (transfer done, endpoint disabled, timeout, IN token met an empty FIFO, NAK now in force). Each pulse latches a sticky bit in that endpoint's status word. Software reads a status word over a simple register bus and clears bits by writing ones. A live FIFO-empty bit sits beside the sticky bits. It is computed from the endpoint's free-space count and from a global threshold select.

Each endpoint also drives one bit of a summary vector: the OR of its sticky bits, gated by a per-endpoint enable input. The global IN-endpoint interrupt flag is the OR of that vector. Clearing an endpoint's pending bits therefore drops its summary bit, and drops the global flag once no endpoint has a pending bit.

Top module: `ep_irq_agg`

## Requirements
- R1: After reset every sticky bit is 0, `allEpSum` is 0 and `inEpIrq` is 0. With every free-space count at capacity, each status word reads 0x80.
- R2: A pulse sets a sticky bit that reads back from the following cycle on. The bit positions are: transfer done at bit 0, disabled at bit 1, timeout at bit 3, token-on-empty at bit 4, NAK in force at bit 6.
- R3: A bus write to endpoint n clears each sticky bit of n whose data bit is 1. Data bits that are 0 have no effect. Other endpoints are untouched. Bits 2, 5 and 31:8 always read 0.
- R4: A set event wins over a clear that targets the same bit in the same cycle. This holds for a bus clear and for a clear-NAK strobe.
- R5: A timeout pulse sets bit 3 only while `isCtrl[n]` is 1.
- R6: A token-on-empty pulse sets bit 4 only while `isPeriodic[n]` is 0.
- R7: A pulse on `clrNak[n]` clears bit 6 of endpoint n.
- R8: Bit 7 is live and read-only. While `emptyLevelSel` is 0 it is 1 when free space is at least CAP/2. While `emptyLevelSel` is 1 it is 1 only when free space equals CAP. The default CAP is 16.
- R9: `allEpSum[n]` is `epIntEn[n]` AND the OR of the sticky bits of n. Bit 7 is not part of that OR. `inEpIrq` is the OR of `allEpSum`.
- R10: Endpoint n is decoded at address 0x908 + n*0x20. Any other address reads 0, and a write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evXfer | input | 4 | Transfer-done pulse, one bit per endpoint |
| evDis | input | 4 | Endpoint-disabled pulse |
| evTout | input | 4 | Timeout pulse |
| evTokEmpty | input | 4 | Pulse for an IN token that met an empty FIFO |
| evNakEff | input | 4 | Pulse that signals NAK is now in force |
| clrNak | input | 4 | Clear-NAK command strobe |
| isCtrl | input | 4 | Endpoint is configured as control |
| isPeriodic | input | 4 | Endpoint is configured as periodic |
| epIntEn | input | 4 | Per-endpoint summary enable |
| fifoFree | input | 20 | Free word count per endpoint, 5 bits each, endpoint 0 in the low bits |
| emptyLevelSel | input | 1 | 0: half-empty threshold, 1: fully-empty threshold |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data, ones clear bits |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| allEpSum | output | 4 | Per-endpoint summary bits |
| inEpIrq | output | 1 | Global IN-endpoint interrupt flag |

## Verification
An event pulse and a clear aimed at the same bit can land in the same cycle. The two clears are a bus write and a clear-NAK strobe. The bench drives a transfer-done pulse in the same cycle as a write of 1 to bit 0 of that endpoint. It also drives a NAK-in-force pulse together with that endpoint's clear-NAK strobe. In both cases the bit must read back as 1 afterwards. The bench further checks that a pending bit on one endpoint survives a write aimed at another endpoint.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int NUM_EP   = 4;
  localparam int STAT_W   = 8;
  localparam int B_XFER   = 0;
  localparam int B_DIS    = 1;
  localparam int B_TOUT   = 3;
  localparam int B_TOK    = 4;
  localparam int B_NAK    = 6;
  localparam int B_TXFE   = 7;
  localparam logic [STAT_W-1:0] STICKY_MASK = 8'b0101_1011;

  typedef struct packed {
    logic [NUM_EP-1:0] wrHit;
    logic [NUM_EP-1:0] rdSel;
    logic [STAT_W-1:0] clrBits;
  } ctlStrobes_t;
endpackage

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
  import ep_irq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 12'h908,
  parameter logic [AW-1:0] STRIDE = 12'h020
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] busWdata,
  output ctlStrobes_t   strobes
);
  logic [DW-STAT_W-1:0] unusedHi;
  assign unusedHi = busWdata[DW-1:STAT_W];

  logic [NUM_EP-1:0] addrMatch;

  for (genvar n = 0; n < NUM_EP; n++) begin : g_dec
    localparam logic [AW-1:0] EP_ADDR = BASE + AW'(n) * STRIDE;
    assign addrMatch[n] = (busAddr == EP_ADDR);
  end

  always_comb begin
    strobes.rdSel   = addrMatch;
    strobes.wrHit   = busWe ? addrMatch : '0;
    strobes.clrBits = busWdata[STAT_W-1:0] & STICKY_MASK;
  end
endmodule

// File: rtl/ep_irq_dp.sv
module ep_irq_dp
  import ep_irq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int CAP = 16,
  localparam int FW = $clog2(CAP + 1),
  localparam int HALF = CAP / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [NUM_EP-1:0]    evXfer,
  input  logic [NUM_EP-1:0]    evDis,
  input  logic [NUM_EP-1:0]    evTout,
  input  logic [NUM_EP-1:0]    evTokEmpty,
  input  logic [NUM_EP-1:0]    evNakEff,
  input  logic [NUM_EP-1:0]    clrNak,
  input  logic [NUM_EP-1:0]    isCtrl,
  input  logic [NUM_EP-1:0]    isPeriodic,
  input  logic [NUM_EP-1:0]    epIntEn,
  input  logic [NUM_EP*FW-1:0] fifoFree,
  input  logic                 emptyLevelSel,
  output logic [DW-1:0]        rdData,
  output logic [NUM_EP-1:0]    epSum
);
  logic [STAT_W-1:0] stQ [NUM_EP];
  logic [STAT_W-1:0] statusW [NUM_EP];

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    logic [STAT_W-1:0] setVec, clrVec, stD;
    logic [FW-1:0]     freeN;
    logic              txfe;

    always_comb begin
      setVec = '0;
      setVec[B_XFER] = evXfer[n];
      setVec[B_DIS]  = evDis[n];
      setVec[B_TOUT] = evTout[n] & isCtrl[n];
      setVec[B_TOK]  = evTokEmpty[n] & ~isPeriodic[n];
      setVec[B_NAK]  = evNakEff[n];
      clrVec = strobes.wrHit[n] ? strobes.clrBits : '0;
      clrVec[B_NAK] = clrVec[B_NAK] | clrNak[n];
      stD = ((stQ[n] & ~clrVec) | setVec) & STICKY_MASK;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stQ[n] <= '0;
      else       stQ[n] <= stD;
    end

    assign freeN = fifoFree[n*FW +: FW];
    assign txfe  = emptyLevelSel ? (freeN >= FW'(CAP)) : (freeN >= FW'(HALF));

    always_comb begin
      statusW[n] = stQ[n];
      statusW[n][B_TXFE] = txfe;
    end

    assign epSum[n] = epIntEn[n] & (|stQ[n]);

    p_xfer_set_r2: assert property (@(posedge clk) disable iff (!rstN)
      evXfer[n] |=> stQ[n][B_XFER]);
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wrHit[n] && strobes.clrBits[B_XFER] && !evXfer[n]) |=> !stQ[n][B_XFER]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      (evNakEff[n] && clrNak[n]) |=> stQ[n][B_NAK]);
    p_tout_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!isCtrl[n] && !stQ[n][B_TOUT]) |=> !stQ[n][B_TOUT]);
    p_tok_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
      (isPeriodic[n] && !stQ[n][B_TOK]) |=> !stQ[n][B_TOK]);
    p_nak_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (clrNak[n] && !evNakEff[n]) |=> !stQ[n][B_NAK]);
  end

  always_comb begin
    rdData = '0;
    for (int n = 0; n < NUM_EP; n++)
      if (strobes.rdSel[n]) rdData = rdData | DW'(statusW[n]);
  end
endmodule

// File: rtl/ep_irq_agg.sv
module ep_irq_agg
  import ep_irq_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CAP = 16,
  localparam int FW = $clog2(CAP + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EP-1:0]    evXfer,
  input  logic [NUM_EP-1:0]    evDis,
  input  logic [NUM_EP-1:0]    evTout,
  input  logic [NUM_EP-1:0]    evTokEmpty,
  input  logic [NUM_EP-1:0]    evNakEff,
  input  logic [NUM_EP-1:0]    clrNak,
  input  logic [NUM_EP-1:0]    isCtrl,
  input  logic [NUM_EP-1:0]    isPeriodic,
  input  logic [NUM_EP-1:0]    epIntEn,
  input  logic [NUM_EP*FW-1:0] fifoFree,
  input  logic                 emptyLevelSel,
  input  logic [AW-1:0]        busAddr,
  input  logic                 busWe,
  input  logic [DW-1:0]        busWdata,
  output logic [DW-1:0]        busRdata,
  output logic [NUM_EP-1:0]    allEpSum,
  output logic                 inEpIrq
);
  ctlStrobes_t strobes;

  ep_irq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .strobes(strobes)
  );

  ep_irq_dp #(.DW(DW), .CAP(CAP)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .evXfer(evXfer), .evDis(evDis), .evTout(evTout),
    .evTokEmpty(evTokEmpty), .evNakEff(evNakEff), .clrNak(clrNak),
    .isCtrl(isCtrl), .isPeriodic(isPeriodic), .epIntEn(epIntEn),
    .fifoFree(fifoFree), .emptyLevelSel(emptyLevelSel),
    .rdData(busRdata), .epSum(allEpSum)
  );

  assign inEpIrq = |allEpSum;

  p_irq_falls_r9: assert property (@(posedge clk) disable iff (!rstN)
    (allEpSum == '0) |-> !inEpIrq);
endmodule

// File: tb/sim_ep_irq_agg.sv
`timescale 1ns/1ps
module sim_ep_irq_agg;
  logic clk = 0, rstN = 0;
  logic [3:0] evXfer = 0, evDis = 0, evTout = 0, evTokEmpty = 0, evNakEff = 0, clrNak = 0;
  logic [3:0] isCtrl = 0, isPeriodic = 0, epIntEn = 4'hF;
  logic [19:0] fifoFree = {4{5'd16}};
  logic emptyLevelSel = 0;
  logic [11:0] busAddr = 0;
  logic busWe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [3:0] allEpSum;
  logic inEpIrq;

  always #4 clk = ~clk;

  ep_irq_agg u0 (.*);

  typedef struct { bit isSum; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event sampleEv;
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [11:0] epAddr(input int n);
    return 12'h908 + 12'(n) * 12'h20;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expRd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.isSum = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sampleEv;
    step();
  endtask

  task automatic expSum(input logic [4:0] e, input string tag);
    item_t it;
    it.isSum = 1; it.exp = {27'b0, e}; it.tag = tag;
    q.push_back(it);
    -> sampleEv;
    step();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1;
    step();
    busWe = 0;
  endtask

  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      @(sampleEv);
      #2;
      it = q.pop_front();
      act = it.isSum ? {27'b0, inEpIrq, allEpSum} : busRdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step();
    // R1 reset state
    for (int n = 0; n < 4; n++) expRd(epAddr(n), 32'h80, "R1 reset read");
    expSum(5'b00000, "R1 reset summary");
    // R2 transfer done sets bit 0
    evXfer = 4'b0001; step(); evXfer = 0;
    expRd(epAddr(0), 32'h81, "R2 xfer bit0");
    expSum(5'b10001, "R9 summary ep0");
    // R3 zero write no effect, other endpoint write no effect
    wr(epAddr(0), 32'h0);
    expRd(epAddr(0), 32'h81, "R3 zero write");
    wr(epAddr(1), 32'hFFFF_FFFF);
    expRd(epAddr(0), 32'h81, "R3 other ep write");
    wr(epAddr(0), 32'h1);
    expRd(epAddr(0), 32'h80, "R3 w1c bit0");
    expSum(5'b00000, "R9 summary falls");
    // R2 disabled + nak, R7 clear nak
    evDis = 4'b0010; evNakEff = 4'b0010; step(); evDis = 0; evNakEff = 0;
    expRd(epAddr(1), 32'hC2, "R2 dis and nak");
    clrNak = 4'b0010; step(); clrNak = 0;
    expRd(epAddr(1), 32'h82, "R7 clear nak");
    // R5 timeout gate
    isCtrl = 4'b0001; evTout = 4'b0011; step(); evTout = 0;
    expRd(epAddr(0), 32'h88, "R5 tout control ep");
    expRd(epAddr(1), 32'h82, "R5 tout non-control ep");
    // R6 token-on-empty gate
    isPeriodic = 4'b0100; evTokEmpty = 4'b1100; step(); evTokEmpty = 0;
    expRd(epAddr(2), 32'h80, "R6 tok periodic ep");
    expRd(epAddr(3), 32'h90, "R6 tok non-periodic ep");
    // R4 set wins over same-cycle clear
    busAddr = epAddr(2); busWdata = 32'h1; busWe = 1; evXfer = 4'b0100;
    evNakEff = 4'b1000; clrNak = 4'b1000;
    step();
    busWe = 0; evXfer = 0; evNakEff = 0; clrNak = 0;
    expRd(epAddr(2), 32'h81, "R4 set beats w1c");
    expRd(epAddr(3), 32'hD0, "R4 set beats clrNak");
    expSum(5'b11111, "R9 all pending");
    // R9 enable gating
    epIntEn = 4'b0000; #1;
    expSum(5'b00000, "R9 all disabled");
    epIntEn = 4'b1000; #1;
    expSum(5'b11000, "R9 only ep3");
    epIntEn = 4'b1111;
    wr(epAddr(0), 32'hFF);
    expRd(epAddr(0), 32'h80, "R3 clear all ep0");
    expSum(5'b11110, "R9 ep0 cleared");
    // R8 FIFO-empty threshold
    fifoFree[4:0] = 5'd8;  expRd(epAddr(0), 32'h80, "R8 half level at half");
    fifoFree[4:0] = 5'd7;  expRd(epAddr(0), 32'h00, "R8 half level below");
    emptyLevelSel = 1;
    fifoFree[4:0] = 5'd15; expRd(epAddr(0), 32'h00, "R8 full level not empty");
    fifoFree[4:0] = 5'd16; expRd(epAddr(0), 32'h80, "R8 full level empty");
    emptyLevelSel = 0;
    // R10 address decode
    expRd(12'h910, 32'h0, "R10 unmapped read");
    expRd(12'h988, 32'h0, "R10 beyond last ep");
    wr(12'h988, 32'hFF);
    expRd(epAddr(1), 32'h82, "R10 unmapped write");
    // R9 global flag falls when all cleared
    wr(epAddr(1), 32'hFF); wr(epAddr(2), 32'hFF); wr(epAddr(3), 32'hFF);
    expRd(epAddr(3), 32'h80, "R3 ep3 cleared");
    expSum(5'b00000, "R9 global falls");
    repeat (3) step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule